// File: doc/BRIEF.md
# PCM Time-Slot Channel Router

This block sits between a shared layer-1 serial data pair (one receive line, one transmit line) and several serial controller ports. An external framer drives a two-bit encoded sync pair that names which logical channel owns the current bit. Code zero means no channel owns the bit. A codes register, written through a plain write strobe and data word, binds each of the three logical channels to a physical controller port or to none. Its reset value leaves every channel unbound.

On every rising edge of the layer-1 clock, the block samples the sync code, the receive bit and the transmit bits offered by the ports. On the next edge it presents the result. The transmit bit of the bound port goes out on the shared line together with a separate pad-driver enable. The received bit goes only to the bound port, together with a one-clock valid strobe for that port. When no port is bound for the sampled code, the driver enable is low and no port sees a strobe.

Top module: `pcm_ts_router`

## Requirements
- R1: While reset is asserted, and from then until the first codes write, every channel is unbound. The driver enable, all valid strobes and all per-port receive bits are 0, and the transmit line holds the idle level (0 by default).
- R2: When the sync code sampled at an edge is 00, the enable from that edge is 0, the transmit line is at the idle level, and no port gets a valid strobe or a receive bit of 1. The received bit is discarded.
- R3: The sync pair is read with the upper line as MSB. Code 01 selects logical channel 1, code 10 selects channel 2 and code 11 selects channel 3. In the codes word, channel k (k = 1..3) owns bits [k*MAP_W-1:(k-1)*MAP_W]. A field value v in 1..NUM_PORTS binds the channel to port v-1. Value 0, or any value above NUM_PORTS, leaves the channel unbound. MAP_W defaults to 2.
- R4: If the code sampled at an edge selects a channel bound to port p, then from that edge until the next one the enable is 1 and the transmit line equals the transmit bit that port p offered at that edge.
- R5: In the same case, from that edge until the next one port p's valid strobe is 1 and its receive bit equals the shared receive bit sampled at that edge. Every other port has strobe 0 and receive bit 0.
- R6: A nonzero code that selects an unbound channel behaves exactly like code 00.
- R7: Two or three channels may be bound to the same port. That port is then served in each of those channels.
- R8: When the write strobe is high at an edge, the whole codes word is loaded at that edge. The routing decided at that same edge still uses the previous binding. The new binding applies from the following edge.
- R9: At most one port's valid strobe is high at any time, and the driver enable is high exactly when some strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Layer-1 bit clock, rising edge used |
| rst_n | input | 1 | Asynchronous active-low reset |
| l1_sync_i | input | 2 | Encoded sync code, bit 1 = upper line |
| l1_rxd_i | input | 1 | Shared layer-1 receive bit |
| l1_txd_o | output | 1 | Shared layer-1 transmit bit |
| l1_txd_oe_o | output | 1 | Pad driver enable for the transmit line |
| cfg_we_i | input | 1 | Codes register write strobe |
| cfg_map_i | input | 3*MAP_W | Channel-to-port binding word |
| port_txd_i | input | NUM_PORTS | Transmit bit offered by each port |
| port_rxd_o | output | NUM_PORTS | Receive bit delivered to each port |
| port_rx_valid_o | output | NUM_PORTS | Per-port receive strobe |

## Verification
The router is first driven with nonzero sync codes while the bindings still hold their reset value. This shows that nothing is routed before a write. With a binding that permutes channels onto ports, all four codes are stepped in order with random data. This tells a correct decode apart from swapped sync lines or swapped channel fields. Runs of code 00, a binding with one channel left unbound, and a binding that shares one port between two channels each isolate the idle and fan-in paths. A rewrite of the codes word while codes keep changing, followed by a long random mix, checks the one-edge delay between a write and the routing it controls.

// File: rtl/pcm_rt_pkg.sv
package pcm_rt_pkg;
   localparam int CODE_W = 2;
   localparam int NUM_CH = (1 << CODE_W) - 1;
   typedef logic [CODE_W-1:0] sync_code_t;
endpackage

// File: rtl/pcm_rt_map_reg.sv
module pcm_rt_map_reg
   import pcm_rt_pkg::*;
#(
   parameter int MAP_W = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [NUM_CH*MAP_W-1:0] wdata,
   output logic [NUM_CH*MAP_W-1:0] map_q
);
   // all fields zero = every channel unbound
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  map_q <= '0;
      else if (we) map_q <= wdata;
   end
endmodule

// File: rtl/pcm_rt_port_sel.sv
module pcm_rt_port_sel
   import pcm_rt_pkg::*;
#(
   parameter int NUM_PORTS = 3,
   parameter int MAP_W     = 2
) (
   input  sync_code_t              code,
   input  logic [NUM_CH*MAP_W-1:0] map,
   output logic [NUM_PORTS-1:0]    port_mask
);
   logic [MAP_W-1:0] sel_field;

   // code 0 leaves sel_field at 0, which matches no port
   always_comb begin
      sel_field = '0;
      for (int ch = 0; ch < NUM_CH; ch++) begin
         if (code == CODE_W'(ch + 1))
            sel_field = map[ch*MAP_W +: MAP_W];
      end
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      assign port_mask[p] = (sel_field == MAP_W'(p + 1));
   end
endmodule

// File: rtl/pcm_rt_lane_reg.sv
module pcm_rt_lane_reg #(
   parameter int NUM_PORTS = 3,
   parameter bit IDLE_TXD  = 1'b0,
   parameter bit GATE_RXD  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PORTS-1:0] port_mask,
   input  logic [NUM_PORTS-1:0] port_txd,
   input  logic                 l1_rxd,
   output logic                 l1_txd_q,
   output logic                 l1_oe_q,
   output logic [NUM_PORTS-1:0] rx_valid_q,
   output logic [NUM_PORTS-1:0] rx_data_q
);
   logic active;
   logic tx_pick;

   assign active  = |port_mask;
   assign tx_pick = |(port_mask & port_txd);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         l1_txd_q <= IDLE_TXD;
         l1_oe_q  <= 1'b0;
      end else begin
         l1_txd_q <= active ? tx_pick : IDLE_TXD;
         l1_oe_q  <= active;
      end
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_lane
      logic rx_bit;
      if (GATE_RXD) begin : g_gated
         assign rx_bit = port_mask[p] & l1_rxd;
      end else begin : g_open
         assign rx_bit = l1_rxd;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rx_valid_q[p] <= 1'b0;
            rx_data_q[p]  <= 1'b0;
         end else begin
            rx_valid_q[p] <= port_mask[p];
            rx_data_q[p]  <= rx_bit;
         end
      end
   end
endmodule

// File: rtl/pcm_ts_router.sv
module pcm_ts_router
   import pcm_rt_pkg::*;
#(
   parameter int NUM_PORTS = 3,
   parameter int MAP_W     = $clog2(NUM_PORTS + 1),
   parameter bit IDLE_TXD  = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [1:0]              l1_sync_i,
   input  logic                    l1_rxd_i,
   output logic                    l1_txd_o,
   output logic                    l1_txd_oe_o,
   input  logic                    cfg_we_i,
   input  logic [3*MAP_W-1:0]      cfg_map_i,
   input  logic [NUM_PORTS-1:0]    port_txd_i,
   output logic [NUM_PORTS-1:0]    port_rxd_o,
   output logic [NUM_PORTS-1:0]    port_rx_valid_o
);
   localparam int MAP_BITS = NUM_CH * MAP_W;

   if (NUM_PORTS < 1) begin : g_bad_ports
      $error("pcm_ts_router: NUM_PORTS must be at least 1");
   end
   if (MAP_W < $clog2(NUM_PORTS + 1)) begin : g_bad_mapw
      $error("pcm_ts_router: MAP_W too narrow to name every port");
   end
   if (NUM_CH != 3) begin : g_bad_ch
      $error("pcm_ts_router: sync code must describe three channels");
   end

   logic [MAP_BITS-1:0]  map_q;
   logic [NUM_PORTS-1:0] port_mask;

   pcm_rt_map_reg #(.MAP_W(MAP_W)) u_map (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we_i),
      .wdata (cfg_map_i),
      .map_q (map_q)
   );

   pcm_rt_port_sel #(.NUM_PORTS(NUM_PORTS), .MAP_W(MAP_W)) u_sel (
      .code      (l1_sync_i),
      .map       (map_q),
      .port_mask (port_mask)
   );

   pcm_rt_lane_reg #(.NUM_PORTS(NUM_PORTS), .IDLE_TXD(IDLE_TXD), .GATE_RXD(1'b1)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .port_mask  (port_mask),
      .port_txd   (port_txd_i),
      .l1_rxd     (l1_rxd_i),
      .l1_txd_q   (l1_txd_o),
      .l1_oe_q    (l1_txd_oe_o),
      .rx_valid_q (port_rx_valid_o),
      .rx_data_q  (port_rxd_o)
   );
endmodule

// File: rtl/pcm_ts_router_chk.sv
module pcm_ts_router_chk #(
   parameter int NUM_PORTS = 3,
   parameter bit IDLE_TXD  = 1'b0
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [1:0]           l1_sync_i,
   input logic                 l1_rxd_i,
   input logic                 l1_txd_o,
   input logic                 l1_txd_oe_o,
   input logic [NUM_PORTS-1:0] port_rxd_o,
   input logic [NUM_PORTS-1:0] port_rx_valid_o
);
   // R1
   always @(posedge clk) begin
      if (!rst_n) begin
         reset_quiet_chk: assert (!l1_txd_oe_o && port_rx_valid_o == '0 && port_rxd_o == '0);
      end
   end

   // R9
   strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(port_rx_valid_o));

   // R9
   oe_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      l1_txd_oe_o == (|port_rx_valid_o));

   // R2
   idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(l1_sync_i) == 2'b00) |-> !l1_txd_oe_o);

   // R2
   idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !l1_txd_oe_o |-> (l1_txd_o == IDLE_TXD));

   // R5
   rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (port_rxd_o & ~port_rx_valid_o) == '0);

   // R5
   rx_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|port_rx_valid_o) |-> ((|port_rxd_o) == $past(l1_rxd_i)));
endmodule

bind pcm_ts_router pcm_ts_router_chk #(.NUM_PORTS(NUM_PORTS), .IDLE_TXD(IDLE_TXD)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .l1_sync_i       (l1_sync_i),
   .l1_rxd_i        (l1_rxd_i),
   .l1_txd_o        (l1_txd_o),
   .l1_txd_oe_o     (l1_txd_oe_o),
   .port_rxd_o      (port_rxd_o),
   .port_rx_valid_o (port_rx_valid_o)
);

// File: tb/tb_pcm_ts_router.sv
module tb_pcm_ts_router;
   localparam int NP = 3;
   localparam int MW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    sync = 2'b00;
   logic          rxd = 1'b0;
   logic          we = 1'b0;
   logic [3*MW-1:0] wmap = '0;
   logic [NP-1:0] ptx = '0;
   logic          txd, oe;
   logic [NP-1:0] prx, pval;

   int checks = 0;
   int fails = 0;
   string tag = "R1";

   // reference model state
   int map_m [3];
   logic exp_txd = 1'b0, exp_oe = 1'b0;
   logic [NP-1:0] exp_val = '0, exp_rxd = '0;
   string exp_tag = "R1";
   bit model_on = 1'b0;

   pcm_ts_router #(.NUM_PORTS(NP)) dut (
      .clk(clk), .rst_n(rst_n), .l1_sync_i(sync), .l1_rxd_i(rxd),
      .l1_txd_o(txd), .l1_txd_oe_o(oe), .cfg_we_i(we), .cfg_map_i(wmap),
      .port_txd_i(ptx), .port_rxd_o(prx), .port_rx_valid_o(pval));

   always #2 clk = ~clk;

   initial begin
      #(200000 * 4);
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   // model: routing decided with the old map, then the write lands (R8)
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < 3; k++) map_m[k] = 0;
         exp_txd = 1'b0; exp_oe = 1'b0; exp_val = '0; exp_rxd = '0; exp_tag = "R1";
      end else begin
         int port;
         int code;
         code = int'(sync);
         port = -1;
         if (code != 0 && map_m[code-1] >= 1 && map_m[code-1] <= NP)
            port = map_m[code-1] - 1;
         exp_tag = (code == 0) ? "R2" : (port < 0 ? "R6" : "R3 R4 R5");
         exp_oe  = (port >= 0);
         exp_txd = (port >= 0) ? ptx[port] : 1'b0;
         exp_val = '0;
         exp_rxd = '0;
         if (port >= 0) begin
            exp_val[port] = 1'b1;
            exp_rxd[port] = rxd;
         end
         if (we)
            for (int k = 0; k < 3; k++) map_m[k] = int'(wmap[k*MW +: MW]);
      end
   end

   task automatic compare();
      checks++;
      if (txd !== exp_txd || oe !== exp_oe || pval !== exp_val || prx !== exp_rxd) begin
         fails++;
         $display("FAIL %s [%s]: actual txd=%b oe=%b val=%b rxd=%b expected txd=%b oe=%b val=%b rxd=%b",
                  exp_tag, tag, txd, oe, pval, prx, exp_txd, exp_oe, exp_val, exp_rxd);
      end
      // R9 one strobe at most, enable tied to strobe
      checks++;
      if ($countones(pval) > 1 || oe !== (|pval)) begin
         fails++;
         $display("FAIL R9: actual oe=%b val=%b expected at most one strobe matching oe", oe, pval);
      end
   endtask

   // one bit period: drive after falling edge, compare on next falling edge
   task automatic bit_cycle(input logic [1:0] s, input logic r, input logic [NP-1:0] t,
                            input logic w, input logic [3*MW-1:0] m);
      sync = s; rxd = r; ptx = t; we = w; wmap = m;
      @(negedge clk);
      if (model_on) compare();
   endtask

   function automatic logic [3*MW-1:0] mk(input int c1, input int c2, input int c3);
      return {MW'(c3), MW'(c2), MW'(c1)};
   endfunction

   initial begin
      @(negedge clk);
      @(negedge clk);
      // R1 reset state
      checks++;
      if (oe !== 1'b0 || pval !== '0 || prx !== '0 || txd !== 1'b0) begin
         fails++;
         $display("FAIL R1: actual oe=%b val=%b rxd=%b txd=%b expected all 0", oe, pval, prx, txd);
      end
      rst_n = 1'b1;
      model_on = 1'b1;
      // R1 bindings start unbound: nonzero codes route nothing
      tag = "R1";
      for (int i = 0; i < 8; i++) bit_cycle(2'(i % 4), 1'b1, '1, 1'b0, '0);
      // R3 R4 R5 permuted binding: ch1->port1, ch2->port0, ch3->port2
      tag = "R3";
      bit_cycle(2'b00, 1'b0, '0, 1'b1, mk(2, 1, 3));
      for (int i = 0; i < 48; i++)
         bit_cycle(2'(i % 4), 1'($urandom), NP'($urandom), 1'b0, '0);
      // R2 long idle with busy data
      tag = "R2";
      for (int i = 0; i < 12; i++) bit_cycle(2'b00, 1'b1, '1, 1'b0, '0);
      // R6 channel 2 unbound
      tag = "R6";
      bit_cycle(2'b00, 1'b0, '0, 1'b1, mk(1, 0, 3));
      for (int i = 0; i < 24; i++)
         bit_cycle(2'(i % 4), 1'b1, '1, 1'b0, '0);
      // R7 channels 1 and 3 share port 1
      tag = "R7";
      bit_cycle(2'b00, 1'b0, '0, 1'b1, mk(2, 3, 2));
      for (int i = 0; i < 24; i++)
         bit_cycle(2'(i % 4), 1'($urandom), NP'($urandom), 1'b0, '0);
      // R8 rewrites while code is active
      tag = "R8";
      for (int i = 0; i < 24; i++)
         bit_cycle(2'(1 + i % 3), 1'($urandom), NP'($urandom), 1'b1,
                   mk(i % 4, (i + 1) % 4, (i + 2) % 4));
      // random mix
      tag = "mix";
      for (int i = 0; i < 300; i++)
         bit_cycle(2'($urandom), 1'($urandom), NP'($urandom), 1'($urandom % 8 == 0),
                   (3*MW)'($urandom));
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule